// File: doc/BRIEF.md
# Handshaked Byte Transfer Engine

This block sits between a host processor and the packet buffers of a small system-management controller. The host owns two active-low handshake wires: a busy line that frames a whole transfer and an acknowledge line that it flips once per byte. The engine watches the pair and moves one byte each time the pair changes while the busy line is asserted. It also drives an active-low request line back to the host. A direction input picks the mode. With the direction bit set, the byte held in the shared 8-bit shift register is appended to an outbound packet store. With the bit clear, the next byte of a previously committed reply is loaded into the shift register for the host to read.

When the host releases the busy line, the transfer is over. If any outbound bytes were gathered, the engine pulses a packet-ready strobe together with the byte count, and the next packet starts again at index zero. If reply bytes are still unread, it pulls the request line low to ask the host to come back and read them. Each of these events schedules a shift-register interrupt that is set after a programmable delay, or on the event's own edge when the bypass input is high. A host read of the shift register clears the interrupt.

Top module: `hs_byte_xfer`

## Requirements
- R1: After reset, req_n is 1, sr_irq is 0, pkt_valid is 0 and sr_data is 0.
- R2: A byte moves on a clock edge only when host_busy_n is 0 and the pair {host_ack_n, host_busy_n} differs from its value at the previous edge. The edge on which host_busy_n is first seen low is a step in its own right. A pair that does not change moves nothing.
- R3: With shift_out=1, each step stores sr_data at the next outbound index, so the first byte of a packet sits at pkt_raddr 0, and schedules an interrupt. Once OUT_DEPTH bytes are stored, further steps store nothing and schedule no interrupt.
- R4: With shift_out=0, each step loads the next committed reply byte into sr_data. The step that takes the last byte drives req_n to 1. Steps made with no reply bytes left leave sr_data unchanged and schedule no interrupt.
- R5: The edge on which host_busy_n is seen going from 0 to 1 always schedules an interrupt. If at least one outbound byte was stored, pkt_valid is 1 for exactly the following cycle with pkt_len equal to the byte count, and the next packet starts at index 0. With no bytes stored, pkt_valid stays 0.
- R6: At that end-of-transfer edge, req_n goes to 0 if committed reply bytes remain unread, and otherwise keeps its value.
- R7: reply_wr writes reply_wdata at reply_waddr. reply_commit sets the reply size to reply_len (clamped to IN_DEPTH), restarts reading at index 0 and schedules an interrupt.
- R8: With irq_bypass=0, sr_irq becomes 1 exactly DELAY_CYC cycles after the edge that schedules an interrupt. A new schedule restarts the count.
- R9: With irq_bypass=1, sr_irq becomes 1 on the scheduling edge itself.
- R10: sr_rd clears sr_irq on its edge unless an interrupt is set on the same edge. A delay already counting is not cancelled and still sets sr_irq when it expires.
- R11: sr_wr loads sr_wdata into sr_data. A reply-byte load on the same edge takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_busy_n | input | 1 | Host transfer-in-progress, active low |
| host_ack_n | input | 1 | Host per-byte acknowledge, active low |
| shift_out | input | 1 | 1: host sends to device; 0: device sends to host |
| irq_bypass | input | 1 | 1: set the interrupt without delay |
| sr_wr | input | 1 | Host write of the shift register |
| sr_wdata | input | 8 | Shift register write data |
| sr_rd | input | 1 | Host read of the shift register (clears interrupt) |
| reply_wr | input | 1 | Write one reply byte |
| reply_waddr | input | clog2(IN_DEPTH) | Reply byte address |
| reply_wdata | input | 8 | Reply byte |
| reply_commit | input | 1 | Publish the reply packet |
| reply_len | input | clog2(IN_DEPTH+1) | Reply packet length in bytes |
| req_n | output | 1 | Transfer request to host, active low |
| sr_data | output | 8 | Shift register contents |
| sr_irq | output | 1 | Shift-register interrupt flag |
| pkt_valid | output | 1 | One-cycle strobe: outbound packet complete |
| pkt_len | output | clog2(OUT_DEPTH+1) | Byte count of the completed packet |
| pkt_raddr | input | clog2(OUT_DEPTH) | Outbound store read address |
| pkt_rdata | output | 8 | Outbound store read data |

## Verification
The bench targets the bytes that lie on either side of a limit. It overfills the outbound store by one byte, which a design with an off-by-one bound would store over a neighbour or count into pkt_len. It also pulls one byte past the end of a reply, which a faulty design would turn into a stale load or a spurious interrupt. It checks that req_n is released on the last reply byte and not one byte later, and that a second packet starts at index zero rather than appending to the first. The delay timer is checked for the exact expiry cycle, for a restart that a design without restart would let expire early, and for a read in mid-count that a design would wrongly let cancel the pending set. A same-edge host write is checked for losing to a reply load.

// File: rtl/hsx_pkg.sv
package hsx_pkg;
   typedef logic [7:0] byte_t;

   typedef struct packed {
      logic ack_n;
      logic busy_n;
   } hs_pair_t;

   localparam hs_pair_t HS_IDLE = '{ack_n: 1'b1, busy_n: 1'b1};
endpackage

// File: rtl/hsx_handshake.sv
module hsx_handshake
   import hsx_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  hs_pair_t pair_i,
   output logic     step_o,
   output logic     end_o
);
   hs_pair_t prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= HS_IDLE;
      else        prev_q <= pair_i;
   end

   assign step_o = !pair_i.busy_n && (pair_i != prev_q);
   assign end_o  = pair_i.busy_n && !prev_q.busy_n;

   // R2
   start_is_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pair_i.busy_n) |-> step_o);

   // R2
   idle_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pair_i.busy_n |-> !step_o);
endmodule

// File: rtl/hsx_irq_delay.sv
module hsx_irq_delay #(
   parameter int DELAY_CYC = 37500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sched_i,
   input  logic bypass_i,
   input  logic clr_i,
   output logic irq_o
);
   generate
      if (DELAY_CYC < 0) begin : g_bad
         $error("hsx_irq_delay: DELAY_CYC must not be negative");
      end

      if (DELAY_CYC == 0) begin : g_direct
         logic unused_bypass;
         assign unused_bypass = bypass_i;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       irq_o <= 1'b0;
            else if (sched_i) irq_o <= 1'b1;
            else if (clr_i)   irq_o <= 1'b0;
         end
      end else begin : g_count
         localparam int CW = $clog2(DELAY_CYC + 1);
         localparam logic [CW-1:0] LOAD = CW'(DELAY_CYC);

         logic [CW-1:0] cnt_q;
         logic          expire;

         assign expire = (cnt_q == CW'(1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt_q <= '0;
            else if (sched_i)      cnt_q <= bypass_i ? '0 : LOAD;
            else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             irq_o <= 1'b0;
            else if ((sched_i && bypass_i) || expire) irq_o <= 1'b1;
            else if (clr_i)                         irq_o <= 1'b0;
         end

         // R9
         bypass_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sched_i && bypass_i) |=> irq_o);

         // R8
         rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_o) |-> ($past(sched_i && bypass_i) || $past(expire)));

         // R10
         clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !sched_i && !expire) |=> !irq_o);
      end
   endgenerate
endmodule

// File: rtl/hsx_byte_store.sv
module hsx_byte_store
   import hsx_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic          clk,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  byte_t         wdata_i,
   input  logic [AW-1:0] raddr_i,
   output byte_t         rdata_o
);
   byte_t cells [DEPTH];

   generate
      if (DEPTH < 1 || (1 << AW) < DEPTH) begin : g_bad
         $error("hsx_byte_store: AW too narrow for DEPTH");
      end

      for (genvar i = 0; i < DEPTH; i++) begin : g_cell
         byte_t cell_q;
         always_ff @(posedge clk) begin
            if (we_i && (waddr_i == AW'(i))) cell_q <= wdata_i;
         end
         assign cells[i] = cell_q;
      end
   endgenerate

   assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/hs_byte_xfer.sv
module hs_byte_xfer
   import hsx_pkg::*;
#(
   parameter int OUT_DEPTH = 16,
   parameter int IN_DEPTH  = 16,
   parameter int DELAY_CYC = 37500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic host_busy_n,
   input  logic host_ack_n,
   input  logic shift_out,
   input  logic irq_bypass,
   input  logic sr_wr,
   input  logic [7:0] sr_wdata,
   input  logic sr_rd,
   input  logic reply_wr,
   input  logic [((IN_DEPTH > 1) ? $clog2(IN_DEPTH) : 1)-1:0] reply_waddr,
   input  logic [7:0] reply_wdata,
   input  logic reply_commit,
   input  logic [$clog2(IN_DEPTH + 1)-1:0] reply_len,
   output logic req_n,
   output logic [7:0] sr_data,
   output logic sr_irq,
   output logic pkt_valid,
   output logic [$clog2(OUT_DEPTH + 1)-1:0] pkt_len,
   input  logic [((OUT_DEPTH > 1) ? $clog2(OUT_DEPTH) : 1)-1:0] pkt_raddr,
   output logic [7:0] pkt_rdata
);
   localparam int OAW = (OUT_DEPTH > 1) ? $clog2(OUT_DEPTH) : 1;
   localparam int IAW = (IN_DEPTH > 1) ? $clog2(IN_DEPTH) : 1;
   localparam int OCW = $clog2(OUT_DEPTH + 1);
   localparam int ICW = $clog2(IN_DEPTH + 1);
   localparam logic [OCW-1:0] OUT_FULL = OCW'(OUT_DEPTH);
   localparam logic [ICW-1:0] IN_FULL  = ICW'(IN_DEPTH);

   generate
      if (OUT_DEPTH < 1 || IN_DEPTH < 1) begin : g_bad_depth
         $error("hs_byte_xfer: buffer depths must be at least 1");
      end
   endgenerate

   hs_pair_t pair;
   logic     step, xfer_end;
   logic [OCW-1:0] wr_idx;
   logic [ICW-1:0] rd_idx, rd_size, len_clamped;
   logic     out_we, in_take, pkt_fire, sched;
   byte_t    reply_byte;

   assign pair = '{ack_n: host_ack_n, busy_n: host_busy_n};

   hsx_handshake u_hs (
      .clk    (clk),
      .rst_n  (rst_n),
      .pair_i (pair),
      .step_o (step),
      .end_o  (xfer_end)
   );

   assign out_we   = step && shift_out && (wr_idx < OUT_FULL);
   assign in_take  = step && !shift_out && !reply_commit && (rd_idx < rd_size);
   assign pkt_fire = xfer_end && (wr_idx != '0);
   assign sched    = out_we || in_take || xfer_end || reply_commit;
   assign len_clamped = (reply_len > IN_FULL) ? IN_FULL : reply_len;

   hsx_byte_store #(.DEPTH(OUT_DEPTH), .AW(OAW)) u_out (
      .clk     (clk),
      .we_i    (out_we),
      .waddr_i (wr_idx[OAW-1:0]),
      .wdata_i (sr_data),
      .raddr_i (pkt_raddr),
      .rdata_o (pkt_rdata)
   );

   hsx_byte_store #(.DEPTH(IN_DEPTH), .AW(IAW)) u_in (
      .clk     (clk),
      .we_i    (reply_wr),
      .waddr_i (reply_waddr),
      .wdata_i (reply_wdata),
      .raddr_i (rd_idx[IAW-1:0]),
      .rdata_o (reply_byte)
   );

   hsx_irq_delay #(.DELAY_CYC(DELAY_CYC)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .sched_i  (sched),
      .bypass_i (irq_bypass),
      .clr_i    (sr_rd),
      .irq_o    (sr_irq)
   );

   // outbound index and packet report
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_idx    <= '0;
         pkt_valid <= 1'b0;
         pkt_len   <= '0;
      end else begin
         pkt_valid <= pkt_fire;
         if (pkt_fire) begin
            pkt_len <= wr_idx;
            wr_idx  <= '0;
         end else if (out_we) begin
            wr_idx <= wr_idx + OCW'(1);
         end
      end
   end

   // reply index, size and request line
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_idx  <= '0;
         rd_size <= '0;
         req_n   <= 1'b1;
      end else begin
         if (reply_commit) begin
            rd_idx  <= '0;
            rd_size <= len_clamped;
         end else if (in_take) begin
            rd_idx <= rd_idx + ICW'(1);
         end

         if (in_take && (rd_idx + ICW'(1) >= rd_size)) req_n <= 1'b1;
         else if (xfer_end && (rd_idx < rd_size))      req_n <= 1'b0;
      end
   end

   // shift register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sr_data <= '0;
      else if (in_take) sr_data <= reply_byte;
      else if (sr_wr)   sr_data <= sr_wdata;
   end

   // R3
   wr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_idx <= OUT_FULL);

   // R5
   pkt_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> (pkt_len != '0));

   // R5
   pkt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |=> !pkt_valid);

   // R4
   req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_n) |-> $past(in_take));

   // R6
   req_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_n) |-> $past(xfer_end));
endmodule

// File: tb/sim_hs_byte_xfer.sv
module sim_hs_byte_xfer;
   localparam int OD = 4;
   localparam int ID = 4;
   localparam int DL = 8;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, busy_n, ack_n, shift_out, bypass;
   logic sr_wr, sr_rd, reply_wr, reply_commit;
   logic [7:0] sr_wdata, reply_wdata;
   logic [1:0] reply_waddr, pkt_raddr;
   logic [2:0] reply_len, pkt_len;
   logic req_n, sr_irq, pkt_valid;
   logic [7:0] sr_data, pkt_rdata;

   int checks = 0;
   int errors = 0;

   hs_byte_xfer #(.OUT_DEPTH(OD), .IN_DEPTH(ID), .DELAY_CYC(DL)) u0 (
      .clk(clk), .rst_n(rst_n), .host_busy_n(busy_n), .host_ack_n(ack_n),
      .shift_out(shift_out), .irq_bypass(bypass), .sr_wr(sr_wr),
      .sr_wdata(sr_wdata), .sr_rd(sr_rd), .reply_wr(reply_wr),
      .reply_waddr(reply_waddr), .reply_wdata(reply_wdata),
      .reply_commit(reply_commit), .reply_len(reply_len), .req_n(req_n),
      .sr_data(sr_data), .sr_irq(sr_irq), .pkt_valid(pkt_valid),
      .pkt_len(pkt_len), .pkt_raddr(pkt_raddr), .pkt_rdata(pkt_rdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // every task starts and ends just after a falling clock edge
   task automatic hs(input logic a, input logic b);
      ack_n = a; busy_n = b;
      @(negedge clk);
   endtask

   task automatic tog();
      hs(~ack_n, busy_n);
   endtask

   task automatic sr_write(input logic [7:0] d);
      sr_wr = 1'b1; sr_wdata = d;
      @(negedge clk);
      sr_wr = 1'b0;
   endtask

   task automatic sr_read();
      sr_rd = 1'b1;
      @(negedge clk);
      sr_rd = 1'b0;
   endtask

   task automatic reply_put(input logic [1:0] a, input logic [7:0] d);
      reply_wr = 1'b1; reply_waddr = a; reply_wdata = d;
      @(negedge clk);
      reply_wr = 1'b0;
   endtask

   task automatic reply_go(input logic [2:0] n);
      reply_commit = 1'b1; reply_len = n;
      @(negedge clk);
      reply_commit = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, input logic [7:0] exp, input string tag);
      pkt_raddr = a;
      #1;
      chk(tag, pkt_rdata, exp);
   endtask

   task automatic t_reset();
      chk("R1 req_n", req_n, 1);
      chk("R1 sr_irq", sr_irq, 0);
      chk("R1 pkt_valid", pkt_valid, 0);
      chk("R1 sr_data", sr_data, 0);
   endtask

   task automatic t_outbound();
      bypass = 1'b1; shift_out = 1'b1;
      sr_write(8'hA1);
      hs(1'b1, 1'b0);
      chk("R9 irq on step edge", sr_irq, 1);
      chk("R2 no packet yet", pkt_valid, 0);
      sr_read();
      chk("R10 read clears", sr_irq, 0);
      hs(1'b1, 1'b0);
      chk("R2 unchanged pair moves nothing", sr_irq, 0);
      sr_write(8'hB2);
      tog();
      chk("R3 second byte irq", sr_irq, 1);
      sr_read();
      hs(ack_n, 1'b1);
      chk("R5 pkt_valid", pkt_valid, 1);
      chk("R5 pkt_len", pkt_len, 2);
      chk("R5 end irq", sr_irq, 1);
      peek(2'd0, 8'hA1, "R3 byte 0");
      peek(2'd1, 8'hB2, "R3 byte 1");
      hs(1'b1, 1'b1);
      chk("R5 pkt_valid one cycle", pkt_valid, 0);
      chk("R6 no reply keeps req_n", req_n, 1);
      sr_read();
   endtask

   task automatic t_overflow();
      sr_write(8'h11);
      hs(ack_n, 1'b0);
      sr_write(8'h22); tog();
      sr_write(8'h33); tog();
      sr_write(8'h44); tog();
      sr_read();
      sr_write(8'h55); tog();
      chk("R3 overflow byte no irq", sr_irq, 0);
      hs(ack_n, 1'b1);
      chk("R3 pkt_len capped", pkt_len, 4);
      peek(2'd3, 8'h44, "R3 last stored byte kept");
      peek(2'd0, 8'h11, "R3 first byte kept");
      sr_read();
      sr_write(8'h66);
      hs(ack_n, 1'b0);
      hs(ack_n, 1'b1);
      chk("R5 restart len", pkt_len, 1);
      peek(2'd0, 8'h66, "R5 restart at index 0");
      sr_read();
   endtask

   task automatic t_reply();
      reply_put(2'd0, 8'hC0);
      reply_put(2'd1, 8'hC1);
      reply_put(2'd2, 8'hC2);
      reply_go(3'd3);
      chk("R7 commit irq", sr_irq, 1);
      chk("R7 commit leaves req_n", req_n, 1);
      sr_read();
      shift_out = 1'b1;
      sr_write(8'h77);
      hs(ack_n, 1'b0);
      hs(ack_n, 1'b1);
      chk("R6 req_n low with reply pending", req_n, 0);
      chk("R5 pkt with reply", pkt_len, 1);
      sr_read();
      shift_out = 1'b0;
      hs(ack_n, 1'b0);
      chk("R4 first reply byte", sr_data, 8'hC0);
      chk("R4 req_n held", req_n, 0);
      tog();
      chk("R4 second reply byte", sr_data, 8'hC1);
      tog();
      chk("R4 last reply byte", sr_data, 8'hC2);
      chk("R4 req_n released on last", req_n, 1);
      sr_read();
      tog();
      chk("R4 exhausted sr kept", sr_data, 8'hC2);
      chk("R4 exhausted no irq", sr_irq, 0);
      hs(ack_n, 1'b1);
      chk("R5 end irq always", sr_irq, 1);
      chk("R5 no bytes no pkt", pkt_valid, 0);
      chk("R6 nothing left req_n", req_n, 1);
      sr_read();
      reply_put(2'd0, 8'hD0);
      reply_put(2'd1, 8'hD1);
      reply_go(3'd2);
      sr_read();
      hs(ack_n, 1'b0);
      chk("R7 index restarts at 0", sr_data, 8'hD0);
      hs(ack_n, 1'b1);
      sr_read();
   endtask

   task automatic t_priority();
      reply_put(2'd0, 8'hE0);
      reply_go(3'd1);
      shift_out = 1'b0;
      sr_wr = 1'b1; sr_wdata = 8'h99;
      hs(ack_n, 1'b0);
      sr_wr = 1'b0;
      chk("R11 reply load wins", sr_data, 8'hE0);
      sr_write(8'h5A);
      chk("R11 host write", sr_data, 8'h5A);
      hs(ack_n, 1'b1);
      sr_read();
   endtask

   task automatic t_delay();
      bypass = 1'b0; shift_out = 1'b1;
      hs(ack_n, 1'b0);
      repeat (DL - 1) @(negedge clk);
      chk("R8 not before delay", sr_irq, 0);
      @(negedge clk);
      chk("R8 set at delay", sr_irq, 1);
      sr_read();
      tog();
      repeat (3) @(negedge clk);
      tog();
      repeat (DL - 1) @(negedge clk);
      chk("R8 restart postpones", sr_irq, 0);
      @(negedge clk);
      chk("R8 restart expiry", sr_irq, 1);
      sr_read();
      tog();
      repeat (2) @(negedge clk);
      sr_read();
      repeat (DL - 4) @(negedge clk);
      chk("R10 pending still counting", sr_irq, 0);
      @(negedge clk);
      chk("R10 pending not cancelled", sr_irq, 1);
      sr_read();
      bypass = 1'b1;
      hs(ack_n, 1'b1);
      chk("R5 delay run len", pkt_len, 4);
      sr_read();
   endtask

   initial begin
      rst_n = 1'b0; busy_n = 1'b1; ack_n = 1'b1; shift_out = 1'b1; bypass = 1'b1;
      sr_wr = 1'b0; sr_rd = 1'b0; reply_wr = 1'b0; reply_commit = 1'b0;
      sr_wdata = '0; reply_wdata = '0; reply_waddr = '0; reply_len = '0; pkt_raddr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_outbound();
      t_overflow();
      t_reply();
      t_priority();
      t_delay();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule